// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit sits beside a memory controller and measures its activity. It holds four counters. Counter 0 is the master: it counts clock cycles and nothing else. Counters 1 to 3 each count one event chosen by an 8-bit select code. Each event is a one-cycle strobe from the controller, such as a read or write access, a command, an activate, a precharge or a refresh. Software uses a simple register bus with write and read strobes. Through it, software arms each counter, clears it, enables it and reads back its count.

The master counter governs the others. An event counter advances only while the master is enabled. When the master wraps, every counter freezes and the interrupt output rises. Software collects the counts, then re-enables the master to release the freeze. Event counters that wrap only set their own flag. They keep counting and raise no interrupt. The counter width is a parameter, 32 bits by default, and every count wraps modulo 2^width. The reset `rst_n` is taken to be already synchronized to `clk`.

Top module: `mcpc_top`

## Requirements
- R1: Counter 0 adds one on every clock while its enable is set and the unit is not frozen. Its select field is ignored and always reads back as 0.
- R2: Counter n (1 to 3) adds one on each clock in which its selected event is present. The event is chosen by control bits 31:24. Code 0 is present on every cycle. Code k from 1 to EVT_W-1 is present when `evt_i[k-1]` is high. Codes of EVT_W and above never count.
- R3: An event counter holds its value unless both its own enable and counter 0's enable are set.
- R4: When counter 0 increments from all ones, it becomes 0 and its overflow flag (control bit 0) sets. `irq_o` rises on the same clock. From the next clock on, no counter changes.
- R5: When an event counter increments from all ones, it becomes 0 and sets its own overflow flag. It keeps counting, `irq_o` stays low and nothing freezes.
- R6: An overflow flag stays set until its control register is written. `irq_o` equals counter 0's overflow flag.
- R7: A write to counter 0's control register with the enable bit (bit 2) set releases the freeze. The master counter does not advance on the clock of that write.
- R8: A control write with bit 1 set zeroes that counter on the clock of the write. Bit 1 always reads back as 0.
- R9: Control register n is at byte address 4n and count register n is at 0x20 + 4n. A control register reads back as {select[7:0], 21'b0, enable, 1'b0, overflow}. Reads of any other address, including misaligned ones, return 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R10: Writes to count registers, to misaligned addresses and to unmapped addresses change no state.
- R11: After reset, every register reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| evt_i | input | EVT_W-1 | Event strobes; bit k-1 carries the event with code k |
| irq_o | output | 1 | Interrupt raised by a master counter overflow |

## Verification
The hardest state to reach is a master wrap while an event counter sits at some other value. At 32 bits this takes four billion cycles. The bench therefore builds the unit with 8-bit counters. It starts the event counter ten cycles after the master, so the two wraps fall on different clocks. The freeze, the sticky interrupt and the release can then be checked apart. A second stretch runs the event counter alone through its own wrap while the master keeps running. A sweep covers every select code from 0 up past the end of the strobe vector, with varied strobe patterns and an alternating enable.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;
  localparam int NUM_CTR = 4;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 8;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int SEL_LSB = 24;

  typedef struct packed {
    logic             en;
    logic             clr;
    logic [SEL_W-1:0] sel;
  } ctl_wr_t;
endpackage

// File: rtl/mcpc_regif.sv
module mcpc_regif
  import mcpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_CTR-1:0][DATA_W-1:0] ctrl_word,
  input  logic [NUM_CTR-1:0][DATA_W-1:0] cnt_word,
  output logic [NUM_CTR-1:0]             ctrl_wr,
  output ctl_wr_t                        wfield,
  output logic [DATA_W-1:0]              bus_rdata
);
  localparam int REG_W = ADDR_W - 4;

  logic [REG_W-1:0] region;
  logic [1:0]       idx;
  logic             aligned;
  logic             hit_ctrl;
  logic             hit_cnt;
  logic             unused_wbits;

  assign region   = bus_addr[ADDR_W-1:4];
  assign idx      = bus_addr[3:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_ctrl = aligned && (region == '0);
  assign hit_cnt  = aligned && (region == REG_W'(2));

  assign wfield.en  = bus_wdata[EN_BIT];
  assign wfield.clr = bus_wdata[CLR_BIT];
  assign wfield.sel = bus_wdata[SEL_LSB +: SEL_W];
  assign unused_wbits = ^{bus_wdata[SEL_LSB-1:EN_BIT+1], bus_wdata[OVF_BIT]};

  always_comb begin
    ctrl_wr = '0;
    if (bus_wr && hit_ctrl) ctrl_wr[idx] = 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)     bus_rdata = ctrl_word[idx];
      else if (hit_cnt) bus_rdata = cnt_word[idx];
    end
  end
endmodule

// File: rtl/mcpc_evsel.sv
module mcpc_evsel
  import mcpc_pkg::*;
#(
  parameter int EVT_W = 64
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [EVT_W-2:0] evt_i,
  output logic             hit_o
);
  localparam int SPAN = 1 << SEL_W;

  logic [SPAN-1:0] ext;

  always_comb begin
    ext = '0;
    ext[EVT_W-1:0] = {evt_i, 1'b1};
  end

  assign hit_o = ext[sel_i];
endmodule

// File: rtl/mcpc_counter.sv
module mcpc_counter
  import mcpc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter bit MASTER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  ctl_wr_t          wf_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             en_q,  en_d;
  logic [SEL_W-1:0] sel_q, sel_d;

  assign wrap_o = inc_i && (&cnt_q);

  always_comb begin
    cnt_d = inc_i ? cnt_q + CNT_W'(1) : cnt_q;
    ovf_d = ovf_q | wrap_o;
    en_d  = en_q;
    sel_d = sel_q;
    if (wr_i) begin
      en_d  = wf_i.en;
      sel_d = MASTER ? '0 : wf_i.sel;
      ovf_d = 1'b0;
      if (wf_i.clr) cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign en_o    = en_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/mcpc_top.sv
module mcpc_top
  import mcpc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int EVT_W  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_W-2:0]  evt_i,
  output logic              irq_o
);
  logic [NUM_CTR-1:0]             ctrl_wr;
  ctl_wr_t                        wfield;
  logic [NUM_CTR-1:0][CNT_W-1:0]  cnt;
  logic [NUM_CTR-1:0][SEL_W-1:0]  sel;
  logic [NUM_CTR-1:0]             ovf;
  logic [NUM_CTR-1:0]             en;
  logic [NUM_CTR-1:0]             wrap;
  logic [NUM_CTR-1:0]             hit;
  logic [NUM_CTR-1:0]             inc;
  logic [NUM_CTR-1:0][DATA_W-1:0] ctrl_word;
  logic [NUM_CTR-1:0][DATA_W-1:0] cnt_word;
  logic                           frz_q, frz_d;

  mcpc_regif #(.ADDR_W(ADDR_W)) u_regif (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_word (ctrl_word),
    .cnt_word  (cnt_word),
    .ctrl_wr   (ctrl_wr),
    .wfield    (wfield),
    .bus_rdata (bus_rdata)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    if (g == 0) begin : g_master
      assign hit[g] = 1'b1;
    end else begin : g_event
      mcpc_evsel #(.EVT_W(EVT_W)) u_evsel (
        .sel_i (sel[g]),
        .evt_i (evt_i),
        .hit_o (hit[g])
      );
    end

    mcpc_counter #(.CNT_W(CNT_W), .MASTER(g == 0)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ctrl_wr[g]),
      .wf_i    (wfield),
      .inc_i   (inc[g]),
      .count_o (cnt[g]),
      .ovf_o   (ovf[g]),
      .en_o    (en[g]),
      .sel_o   (sel[g]),
      .wrap_o  (wrap[g])
    );

    always_comb begin
      ctrl_word[g] = '0;
      ctrl_word[g][SEL_LSB +: SEL_W] = sel[g];
      ctrl_word[g][EN_BIT]           = en[g];
      ctrl_word[g][OVF_BIT]          = ovf[g];
    end
    assign cnt_word[g] = DATA_W'(cnt[g]);
  end

  // Master gating: event counters need counter 0 running and unfrozen
  always_comb begin
    inc[0] = en[0] && !frz_q;
    for (int n = 1; n < NUM_CTR; n++) begin
      inc[n] = en[n] && en[0] && !frz_q && hit[n];
    end
  end

  always_comb begin
    frz_d = frz_q;
    if (wrap[0]) frz_d = 1'b1;
    if (ctrl_wr[0] && wfield.en) frz_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  assign irq_o = ovf[0];
endmodule

// File: rtl/mcpc_checker.sv
module mcpc_checker
  import mcpc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          irq_o,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CTR-1:0]            en,
  input logic                          frz
);
  logic [NUM_CTR-1:0] wr_c;
  logic               unused_cbits;

  assign unused_cbits = ^{bus_wdata[31:EN_BIT+1], bus_wdata[OVF_BIT]};

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_wr
    assign wr_c[n] = bus_wr && (bus_addr == ADDR_W'(4 * n));
  end

  // R1: master steps by one while running
  a_r1_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    en[0] && !frz && !wr_c[0] |=> cnt[0] == $past(cnt[0]) + CNT_W'(1));

  // R4: frozen while interrupt is up
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !wr_c[0] |=> $stable(cnt));

  // R5: interrupt can only come from the master wrapping
  a_r5_no_evt_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && !(&cnt[0]) |=> !irq_o);

  // R6: interrupt is sticky
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !wr_c[0] |=> irq_o);

  // R7: enabling the master drops the interrupt
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c[0] && bus_wdata[EN_BIT] |=> !irq_o);

  // R9: idle read data
  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'h0);

  for (genvar n = 1; n < NUM_CTR; n++) begin : g_evt
    // R3: event counters halt with the master disabled
    a_r3_halt_evt: assert property (@(posedge clk) disable iff (!rst_n)
      !en[0] && !wr_c[n] |=> $stable(cnt[n]));
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_clr
    // R8: clear zeroes the count
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c[n] && bus_wdata[CLR_BIT] |=> cnt[n] == '0);
  end
endmodule

bind mcpc_top mcpc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .cnt       (cnt),
  .en        (en),
  .frz       (frz_q)
);

// File: tb/tb_mcpc_top.sv
module tb_mcpc_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 8;
  localparam int EVT_W = 64;
  localparam logic [31:0] EN  = 32'h4;
  localparam logic [31:0] CLR = 32'h2;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [EVT_W-2:0] evt_i;
  logic        irq_o;

  int total;
  int fails;

  mcpc_top #(.CNT_W(CNT_W), .EVT_W(EVT_W), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_cnt(input logic [7:0] code, input logic [62:0] m,
                                             input bit on, input int n);
    if (!on) return 0;
    if (code == 0) return n;
    if (code < EVT_W) return m[code-1] ? n : 0;
    return 0;
  endfunction

  initial begin
    #(CLK_P * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 irq", 32'(irq_o), 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), 0, "R11 ctrl");
      rd(8'(32'h20 + 4*i), 0, "R11 count");
    end

    // R1: master counts cycles, select field ignored
    wr(8'h00, EN | CLR | 32'h3700_0000);
    rd(8'h00, 32'h4, "R1 sel reads 0");
    idle(19);
    wr(8'h00, 0);
    rd(8'h20, 21, "R1 cycle count");
    rd(8'h24, 0, "R3 own enable off");

    // R3: event counter halted while master disabled
    wr(8'h04, EN | CLR);
    idle(5);
    rd(8'h24, 0, "R3 master off");

    // R2/R3: sweep of select codes and strobe patterns
    for (int k = 0; k <= 70; k++) begin
      logic [31:0] h;
      logic [62:0] m;
      logic [7:0]  c2;
      int          nrun;
      h = 32'h9E3779B9 * 32'(k + 1);
      m = {h[30:0], h};
      c2 = 8'(k * 3 + 5);
      nrun = (k % 7) + 2;
      evt_i = m;
      wr(8'h04, EN | CLR | {8'(k), 24'h0});
      wr(8'h08, ((k % 2) ? EN : 0) | CLR | {c2, 24'h0});
      wr(8'h0C, EN | CLR | 32'h3700_0000);
      wr(8'h00, EN | CLR);
      idle(nrun);
      wr(8'h00, 0);
      rd(8'h24, expect_cnt(8'(k), m, 1'b1, nrun + 1), "R2 counter1 code sweep");
      rd(8'h28, expect_cnt(c2, m, (k % 2) == 1, nrun + 1), "R3 counter2 enable");
      rd(8'h2C, expect_cnt(8'h37, m, 1'b1, nrun + 1), "R2 counter3 code 0x37");
    end
    evt_i = '0;

    // R4: master wrap freezes everything
    wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h00, EN | CLR);
    idle(9);
    wr(8'h04, EN | CLR);
    idle(244);
    check("R5 no irq before wrap", 32'(irq_o), 0);
    idle(2);
    check("R4 irq on wrap", 32'(irq_o), 1);
    idle(5);
    check("R6 irq sticky", 32'(irq_o), 1);
    rd(8'h20, 0, "R4 master wrapped");
    rd(8'h24, 246, "R4 event frozen");
    rd(8'h00, 32'h5, "R4 master ovf flag");
    rd(8'h04, 32'h4, "R4 event ovf clear");

    // R7: re-enable releases
    wr(8'h00, EN);
    check("R7 irq dropped", 32'(irq_o), 0);
    idle(3);
    wr(8'h00, 0);
    rd(8'h20, 4, "R7 master resumed");
    rd(8'h24, 250, "R7 event resumed");

    // R5: event wrap is silent
    wr(8'h00, EN);
    idle(8);
    check("R5 no irq on event wrap", 32'(irq_o), 0);
    wr(8'h00, 0);
    rd(8'h20, 13, "R5 master kept running");
    rd(8'h24, 3, "R5 event kept counting");
    rd(8'h04, 32'h5, "R5 event ovf flag");
    rd(8'h00, 32'h0, "R6 master ovf cleared by write");

    // R6: rewrite clears event flag
    wr(8'h04, EN);
    rd(8'h04, 32'h4, "R6 event ovf cleared by write");
    rd(8'h24, 3, "R6 count kept");

    // R8: clear
    wr(8'h04, EN | CLR);
    rd(8'h04, 32'h4, "R8 clear bit reads 0");
    rd(8'h24, 0, "R8 count zeroed");

    // R10: ignored writes
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 0, "R10 count write ignored");
    wr(8'h03, EN | CLR);
    rd(8'h00, 0, "R10 misaligned write ignored");
    rd(8'h20, 13, "R10 misaligned no clear");
    wr(8'h40, EN);
    rd(8'h00, 0, "R10 unmapped write ignored");
    idle(3);
    rd(8'h20, 13, "R10 master still off");

    // R9: unmapped reads and idle read data
    rd(8'h10, 0, "R9 unmapped 0x10");
    rd(8'h30, 0, "R9 unmapped 0x30");
    rd(8'h22, 0, "R9 misaligned 0x22");
    rd(8'hFC, 0, "R9 unmapped 0xFC");
    bus_addr = 8'h20;
    #1;
    check("R9 rdata idle", bus_rdata, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule